// File: doc/BRIEF.md
# Multi-channel DMA global control and status registers

This block is the shared register file of a DMA controller with up to 64 channels. Software reaches it over a simple 32-bit register port. The channel engines use it as their common status point. For every channel it keeps five bits: request enable, error-interrupt enable, interrupt request, error flag, and a start strobe. It also holds the arbitration control bits and one priority byte per channel. It records the first reported error in a single status word, which gives the channel number and the cause bits.

Software changes a single channel without a read-modify-write. It writes the channel number into one byte lane of a command word. Lanes 0 to 3 of word 0x18 set request enable, clear request enable, set error-interrupt enable and clear error-interrupt enable. Lanes 0 to 3 of word 0x1C clear the interrupt request, clear the error flag, start the channel and clear the done indication. The channel engines report interrupt and error events on per-channel inputs. The block combines all pending requests into one interrupt line.

Top module: `dma_glb_regs`

## Requirements
- R1: After reset the following are zero: request enables, error-interrupt enables, interrupt bits, error bits, the control word and the error status word. Priority byte n reads back as n.
- R2: A word write to 0x08 loads the request enables of channels 63..32 and a word write to 0x0C loads channels 31..0; `req_en` and reads of both words reflect them. Error-interrupt enables use 0x10 (high) and 0x14 (low) in the same way.
- R3: A write to 0x18 with byte lane k enabled, where lane k is wdata[8k+7:8k], applies that lane's channel number. Lane 0 sets request enable, lane 1 clears it, lane 2 sets error-interrupt enable and lane 3 clears it. Several lanes may act in one write.
- R4: An interrupt event on a channel sets its interrupt bit, read at 0x20 (63..32) and 0x24 (31..0). Writing ones there clears bits, and so does lane 0 of 0x1C. An event in the same cycle as a clear leaves the bit set.
- R5: An error event sets the channel's error bit, read at 0x28 and 0x2C. Writing ones there clears bits, and so does lane 1 of 0x1C. An event wins over a clear in the same cycle.
- R6: While the status word at 0x04 is not valid, an error event loads it, and among simultaneous events the lowest channel is captured. The layout is: bit 31 valid, bits 13:8 channel, bits 15 and 14 from cause bits 9 and 8, and bits 7:0 from cause bits 7:0. Further errors leave a valid word unchanged.
- R7: A clear-error command (0x1C lane 1) with an in-range channel zeroes the status word, so that a later error is captured again. An error in the same cycle is captured.
- R8: A start command (0x1C lane 2) drives `start_pulse` high for exactly one cycle, the cycle after the write, on that channel only. A clear-done command (0x1C lane 3) does the same on `done_clr`.
- R9: `irq_out` is high when any interrupt bit is set, or when some channel has both its error bit and its error-interrupt enable set.
- R10: A command byte with a channel number of 64 or more (or at least NCH) has no effect on any register or output.
- R11: The control word at 0x00 stores only bit 31 (clock gating), bit 3 (round-robin groups) and bit 2 (round-robin channels). The three control outputs follow these bits, and all other bits read zero.
- R12: Priority bytes sit at 0x100 + channel and are written per byte lane. The hardware request inputs read back at 0x30 (63..32) and 0x34 (31..0). Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register word |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_irq | input | NCH | Per-channel interrupt event |
| evt_err | input | NCH | Per-channel error event |
| evt_cause | input | 10 | Cause bits of the error being reported |
| hw_req | input | NCH | Per-channel hardware request level |
| req_en | output | NCH | Per-channel request enable |
| start_pulse | output | NCH | One-cycle start strobe |
| done_clr | output | NCH | One-cycle done-clear strobe |
| prio_flat | output | 8*NCH | Priority bytes, channel n at bits 8n+7:8n |
| ctrl_rr_chan | output | 1 | Round-robin channel arbitration |
| ctrl_rr_grp | output | 1 | Round-robin group arbitration |
| ctrl_clk_gate | output | 1 | Dynamic clock gating enable |
| irq_out | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is when several things land in one clock edge. One example is a clear of the error status word together with a fresh error event. Another is a write-one-to-clear together with an event on the same channel. A third is several error events at once while the status word is already valid. Directed steps create each collision on purpose. A long random phase then mixes sparse event vectors, random command bytes that include out-of-range channel numbers, and random byte lanes. Every cycle the outputs are compared against a bench model, and the full register map is read back at regular intervals.

// File: rtl/dmagr_pkg.sv
package dmagr_pkg;
  localparam int unsigned AW      = 12;
  localparam int unsigned MAXCH   = 64;
  localparam int unsigned CAUSE_W = 10;
  localparam int unsigned CHW     = 6;

  localparam logic [AW-1:0] A_CTRL   = 12'h000;
  localparam logic [AW-1:0] A_ESTAT  = 12'h004;
  localparam logic [AW-1:0] A_REQ_HI = 12'h008;
  localparam logic [AW-1:0] A_REQ_LO = 12'h00C;
  localparam logic [AW-1:0] A_EEI_HI = 12'h010;
  localparam logic [AW-1:0] A_EEI_LO = 12'h014;
  localparam logic [AW-1:0] A_CMD_EN = 12'h018;
  localparam logic [AW-1:0] A_CMD_EV = 12'h01C;
  localparam logic [AW-1:0] A_INT_HI = 12'h020;
  localparam logic [AW-1:0] A_INT_LO = 12'h024;
  localparam logic [AW-1:0] A_ERR_HI = 12'h028;
  localparam logic [AW-1:0] A_ERR_LO = 12'h02C;
  localparam logic [AW-1:0] A_HRS_HI = 12'h030;
  localparam logic [AW-1:0] A_HRS_LO = 12'h034;

  localparam logic [31:0] CTRL_MASK = 32'h8000_000C;

  // status word: valid | cause[9:8] at 15:14 | channel at 13:8 | cause[7:0]
  function automatic logic [31:0] pack_err(input logic [CHW-1:0] ch,
                                           input logic [CAUSE_W-1:0] cause);
    logic [31:0] w;
    w        = '0;
    w[31]    = 1'b1;
    w[15:14] = cause[9:8];
    w[13:8]  = ch;
    w[7:0]   = cause[7:0];
    return w;
  endfunction

  function automatic logic [CHW-1:0] lowest_set(input logic [MAXCH-1:0] v);
    logic [CHW-1:0] idx;
    idx = '0;
    for (int i = MAXCH - 1; i >= 0; i--)
      if (v[i]) idx = CHW'(i);
    return idx;
  endfunction
endpackage

// File: rtl/dmagr_cmd_decode.sv
module dmagr_cmd_decode #(
  parameter int unsigned NCH = 64
) (
  input  logic           bus_we,
  input  logic           hit_en,
  input  logic           hit_ev,
  input  logic [3:0]     bus_be,
  input  logic [31:0]    bus_wdata,
  output logic [NCH-1:0] en_set,
  output logic [NCH-1:0] en_clr,
  output logic [NCH-1:0] eei_set,
  output logic [NCH-1:0] eei_clr,
  output logic [NCH-1:0] int_clr,
  output logic [NCH-1:0] err_clr,
  output logic [NCH-1:0] start_cmd,
  output logic [NCH-1:0] done_cmd
);
  localparam int unsigned LANES = 4;

  // one-hot image of each lane's channel byte; out-of-range bytes give zero
  logic [LANES-1:0][NCH-1:0] oh;
  logic [LANES-1:0]          sel_en, sel_ev;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign oh[k][c] = (bus_wdata[8*k +: 8] == 8'(c));
    end
    assign sel_en[k] = bus_we & hit_en & bus_be[k];
    assign sel_ev[k] = bus_we & hit_ev & bus_be[k];
  end

  assign en_set    = sel_en[0] ? oh[0] : '0;
  assign en_clr    = sel_en[1] ? oh[1] : '0;
  assign eei_set   = sel_en[2] ? oh[2] : '0;
  assign eei_clr   = sel_en[3] ? oh[3] : '0;
  assign int_clr   = sel_ev[0] ? oh[0] : '0;
  assign err_clr   = sel_ev[1] ? oh[1] : '0;
  assign start_cmd = sel_ev[2] ? oh[2] : '0;
  assign done_cmd  = sel_ev[3] ? oh[3] : '0;
endmodule

// File: rtl/dmagr_chan_bits.sv
module dmagr_chan_bits import dmagr_pkg::*; #(
  parameter int unsigned NCH = 64,
  parameter bit          W1C = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_hi,
  input  logic           wr_lo,
  input  logic [31:0]    wdata,
  input  logic [NCH-1:0] set_v,
  input  logic [NCH-1:0] clr_v,
  output logic [NCH-1:0] q
);
  logic [MAXCH-1:0] cur;
  logic [NCH-1:0]   nxt;

  if (W1C) begin : g_w1c
    always_comb begin
      cur = MAXCH'(q);
      if (wr_lo) cur[31:0]  = cur[31:0]  & ~wdata;
      if (wr_hi) cur[63:32] = cur[63:32] & ~wdata;
    end
  end else begin : g_load
    always_comb begin
      cur = MAXCH'(q);
      if (wr_lo) cur[31:0]  = wdata;
      if (wr_hi) cur[63:32] = wdata;
    end
  end

  // a set in the same cycle as any clear wins
  assign nxt = (cur[NCH-1:0] & ~clr_v) | set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/dmagr_err_status.sv
module dmagr_err_status import dmagr_pkg::*; #(
  parameter int unsigned NCH = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     evt_err,
  input  logic [CAUSE_W-1:0] evt_cause,
  input  logic               clr_valid,
  output logic [31:0]        word
);
  logic held, take;

  assign held = word[31] & ~clr_valid;
  assign take = ~held & (|evt_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word <= '0;
    else if (take)      word <= pack_err(lowest_set(MAXCH'(evt_err)), evt_cause);
    else if (clr_valid) word <= '0;
  end
endmodule

// File: rtl/dmagr_prio_file.sv
module dmagr_prio_file #(
  parameter int unsigned NCH = 64,
  parameter int unsigned IW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [IW-1:0]    idx,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic [8*NCH-1:0] prio_flat,
  output logic [31:0]      rd_word
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= 8'(c);
      else if (wr_hit && idx == IW'(c / 4) && bus_be[c % 4])
        q <= bus_wdata[8*(c % 4) +: 8];
    end
    assign prio_flat[8*c +: 8] = q;
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < 4; k++) begin
      if (int'(idx) * 4 + k < NCH)
        rd_word[8*k +: 8] = prio_flat[8*(int'(idx) * 4 + k) +: 8];
    end
  end
endmodule

// File: rtl/dma_glb_regs.sv
module dma_glb_regs import dmagr_pkg::*; #(
  parameter int unsigned NCH = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NCH-1:0]     evt_irq,
  input  logic [NCH-1:0]     evt_err,
  input  logic [CAUSE_W-1:0] evt_cause,
  input  logic [NCH-1:0]     hw_req,
  output logic [NCH-1:0]     req_en,
  output logic [NCH-1:0]     start_pulse,
  output logic [NCH-1:0]     done_clr,
  output logic [8*NCH-1:0]   prio_flat,
  output logic               ctrl_rr_chan,
  output logic               ctrl_rr_grp,
  output logic               ctrl_clk_gate,
  output logic               irq_out
);
  localparam int unsigned PRIO_WORDS = (NCH + 3) / 4;
  localparam int unsigned IW = 6;

  // named internal state, also observed by the checker
  logic [NCH-1:0] eei_bits, int_bits, err_bits;
  logic [31:0]    err_word, ctrl_q, prio_rd;
  logic [NCH-1:0] en_set, en_clr, eei_set, eei_clr, int_clr, err_clr;
  logic [NCH-1:0] start_cmd, done_cmd;
  logic           prio_hit;

  function automatic logic [MAXCH-1:0] pad(input logic [NCH-1:0] v);
    return MAXCH'(v);
  endfunction

  function automatic logic wr_at(input logic [AW-1:0] a);
    return bus_we && (bus_addr == a);
  endfunction

  dmagr_cmd_decode #(.NCH(NCH)) u_dec (
    .bus_we(bus_we), .hit_en(bus_addr == A_CMD_EN), .hit_ev(bus_addr == A_CMD_EV),
    .bus_be(bus_be), .bus_wdata(bus_wdata),
    .en_set(en_set), .en_clr(en_clr), .eei_set(eei_set), .eei_clr(eei_clr),
    .int_clr(int_clr), .err_clr(err_clr), .start_cmd(start_cmd), .done_cmd(done_cmd)
  );

  dmagr_chan_bits #(.NCH(NCH), .W1C(1'b0)) u_req (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_at(A_REQ_HI)), .wr_lo(wr_at(A_REQ_LO)),
    .wdata(bus_wdata), .set_v(en_set), .clr_v(en_clr), .q(req_en)
  );

  dmagr_chan_bits #(.NCH(NCH), .W1C(1'b0)) u_eei (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_at(A_EEI_HI)), .wr_lo(wr_at(A_EEI_LO)),
    .wdata(bus_wdata), .set_v(eei_set), .clr_v(eei_clr), .q(eei_bits)
  );

  dmagr_chan_bits #(.NCH(NCH), .W1C(1'b1)) u_int (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_at(A_INT_HI)), .wr_lo(wr_at(A_INT_LO)),
    .wdata(bus_wdata), .set_v(evt_irq), .clr_v(int_clr), .q(int_bits)
  );

  dmagr_chan_bits #(.NCH(NCH), .W1C(1'b1)) u_err (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_at(A_ERR_HI)), .wr_lo(wr_at(A_ERR_LO)),
    .wdata(bus_wdata), .set_v(evt_err), .clr_v(err_clr), .q(err_bits)
  );

  dmagr_err_status #(.NCH(NCH)) u_est (
    .clk(clk), .rst_n(rst_n), .evt_err(evt_err), .evt_cause(evt_cause),
    .clr_valid(|err_clr), .word(err_word)
  );

  assign prio_hit = (bus_addr[AW-1:8] == (AW-8)'(1)) && (bus_addr[1:0] == 2'b00)
                    && (bus_addr[7:2] < IW'(PRIO_WORDS));

  dmagr_prio_file #(.NCH(NCH), .IW(IW)) u_prio (
    .clk(clk), .rst_n(rst_n), .wr_hit(bus_we && prio_hit), .idx(bus_addr[7:2]),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .prio_flat(prio_flat), .rd_word(prio_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      start_pulse <= '0;
      done_clr    <= '0;
    end else begin
      if (wr_at(A_CTRL)) ctrl_q <= bus_wdata & CTRL_MASK;
      start_pulse <= start_cmd;
      done_clr    <= done_cmd;
    end
  end

  assign ctrl_clk_gate = ctrl_q[31];
  assign ctrl_rr_grp   = ctrl_q[3];
  assign ctrl_rr_chan  = ctrl_q[2];

  assign irq_out = (|int_bits) | (|(err_bits & eei_bits));

  always_comb begin
    bus_rdata = '0;
    if (prio_hit) bus_rdata = prio_rd;
    else begin
      case (bus_addr)
        A_CTRL:   bus_rdata = ctrl_q;
        A_ESTAT:  bus_rdata = err_word;
        A_REQ_HI: bus_rdata = pad(req_en)[63:32];
        A_REQ_LO: bus_rdata = pad(req_en)[31:0];
        A_EEI_HI: bus_rdata = pad(eei_bits)[63:32];
        A_EEI_LO: bus_rdata = pad(eei_bits)[31:0];
        A_INT_HI: bus_rdata = pad(int_bits)[63:32];
        A_INT_LO: bus_rdata = pad(int_bits)[31:0];
        A_ERR_HI: bus_rdata = pad(err_bits)[63:32];
        A_ERR_LO: bus_rdata = pad(err_bits)[31:0];
        A_HRS_HI: bus_rdata = pad(hw_req)[63:32];
        A_HRS_LO: bus_rdata = pad(hw_req)[31:0];
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dmagr_chk.sv
module dmagr_chk import dmagr_pkg::*; #(
  parameter int unsigned NCH = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic [3:0]     bus_be,
  input logic [31:0]    bus_wdata,
  input logic [NCH-1:0] evt_irq,
  input logic [NCH-1:0] evt_err,
  input logic           irq_out,
  input logic [NCH-1:0] start_pulse,
  input logic [NCH-1:0] req_en,
  input logic [NCH-1:0] int_bits,
  input logic [NCH-1:0] err_bits,
  input logic [31:0]    err_word
);
  logic clr_err_cmd, start_wr, bad_set_only;

  assign clr_err_cmd  = bus_we && bus_addr == A_CMD_EV && bus_be[1]
                        && (int'(bus_wdata[15:8]) < NCH);
  assign start_wr     = bus_we && bus_addr == A_CMD_EV && bus_be[2];
  assign bad_set_only = bus_we && bus_addr == A_CMD_EN && bus_be == 4'b0001
                        && (int'(bus_wdata[7:0]) >= NCH);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (req_en == '0 && int_bits == '0 && err_bits == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    p_int_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_irq[c] |=> int_bits[c]);
    p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_err[c] |=> err_bits[c]);
  end

  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_word[31] && !clr_err_cmd) |=> $stable(err_word));

  p_start_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_pulse));

  p_start_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_pulse) |-> $past(start_wr));

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_irq) |=> irq_out);

  p_bad_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_set_only |=> $stable(req_en));
endmodule

bind dma_glb_regs dmagr_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
  .bus_wdata(bus_wdata), .evt_irq(evt_irq), .evt_err(evt_err), .irq_out(irq_out),
  .start_pulse(start_pulse), .req_en(req_en), .int_bits(int_bits),
  .err_bits(err_bits), .err_word(err_word)
);

// File: tb/tb_dma_glb_regs.sv
module tb_dma_glb_regs;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [3:0]    bus_be = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  evt_irq = '0, evt_err = '0, hw_req = '0;
  logic [9:0]    evt_cause = '0;
  logic [N-1:0]  req_en, start_pulse, done_clr;
  logic [8*N-1:0] prio_flat;
  logic          ctrl_rr_chan, ctrl_rr_grp, ctrl_clk_gate, irq_out;

  int total = 0, bad = 0;

  // bench model
  logic [63:0] m_req, m_eei, m_int, m_err, m_hw, m_start, m_done;
  logic [31:0] m_ctrl, m_ew;
  logic [7:0]  m_prio [N];

  always #2 clk = ~clk;

  dma_glb_regs #(.NCH(N)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_irq(evt_irq), .evt_err(evt_err),
    .evt_cause(evt_cause), .hw_req(hw_req), .req_en(req_en), .start_pulse(start_pulse),
    .done_clr(done_clr), .prio_flat(prio_flat), .ctrl_rr_chan(ctrl_rr_chan),
    .ctrl_rr_grp(ctrl_rr_grp), .ctrl_clk_gate(ctrl_clk_gate), .irq_out(irq_out)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] status_of(input logic [5:0] ch, input logic [9:0] c);
    return {1'b1, 15'd0, c[9], c[8], ch, c[7:0]};
  endfunction

  function automatic logic model_irq();
    return (m_int != 0) || ((m_err & m_eei) != 0);
  endfunction

  task automatic model_reset();
    m_req = 0; m_eei = 0; m_int = 0; m_err = 0; m_hw = 0; m_start = 0; m_done = 0;
    m_ctrl = 0; m_ew = 0;
    for (int i = 0; i < N; i++) m_prio[i] = 8'(i);
  endtask

  task automatic model_step(input logic we, input logic [11:0] a, input logic [3:0] be,
                            input logic [31:0] d, input logic [63:0] ei,
                            input logic [63:0] ee, input logic [9:0] c);
    logic [63:0] s_en, c_en, s_ei, c_ei, c_int, c_err, st, dn;
    logic [7:0]  b;
    logic [5:0]  lo;
    s_en = 0; c_en = 0; s_ei = 0; c_ei = 0; c_int = 0; c_err = 0; st = 0; dn = 0;
    for (int k = 0; k < 4; k++) begin
      b = d[8*k +: 8];
      if (we && be[k] && b < 8'(N)) begin
        if (a == 12'h018) begin
          if (k == 0) s_en[b] = 1; if (k == 1) c_en[b] = 1;
          if (k == 2) s_ei[b] = 1; if (k == 3) c_ei[b] = 1;
        end else if (a == 12'h01C) begin
          if (k == 0) c_int[b] = 1; if (k == 1) c_err[b] = 1;
          if (k == 2) st[b] = 1;    if (k == 3) dn[b] = 1;
        end
      end
    end
    if (we) begin
      case (a)
        12'h000: m_ctrl = d & 32'h8000_000C;
        12'h008: m_req[63:32] = d;
        12'h00C: m_req[31:0]  = d;
        12'h010: m_eei[63:32] = d;
        12'h014: m_eei[31:0]  = d;
        12'h020: m_int[63:32] = m_int[63:32] & ~d;
        12'h024: m_int[31:0]  = m_int[31:0] & ~d;
        12'h028: m_err[63:32] = m_err[63:32] & ~d;
        12'h02C: m_err[31:0]  = m_err[31:0] & ~d;
        default: ;
      endcase
      if (a >= 12'h100 && a < 12'h100 + 12'(N) && a[1:0] == 0)
        for (int k = 0; k < 4; k++)
          if (be[k]) m_prio[int'(a - 12'h100) + k] = d[8*k +: 8];
    end
    m_req = (m_req & ~c_en) | s_en;
    m_eei = (m_eei & ~c_ei) | s_ei;
    m_int = (m_int & ~c_int) | ei;
    m_err = (m_err & ~c_err) | ee;
    lo = 0;
    for (int i = N - 1; i >= 0; i--) if (ee[i]) lo = 6'(i);
    if (!(m_ew[31] && c_err == 0) && ee != 0) m_ew = status_of(lo, c);
    else if (c_err != 0) m_ew = 0;
    m_start = st; m_done = dn;
  endtask

  // one clock: drive at negedge, model at posedge, check outputs at next negedge
  task automatic cyc(input logic we, input logic [11:0] a, input logic [3:0] be,
                     input logic [31:0] d, input logic [63:0] ei, input logic [63:0] ee,
                     input logic [9:0] c);
    bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d;
    evt_irq = ei; evt_err = ee; evt_cause = c;
    @(posedge clk);
    model_step(we, a, be, d, ei, ee, c);
    @(negedge clk);
    bus_we = 0; evt_irq = 0; evt_err = 0;
    chk(req_en == m_req, "R3 req_en", req_en, m_req);
    chk(irq_out == model_irq(), "R9 irq_out", 64'(irq_out), 64'(model_irq()));
    chk(start_pulse == m_start, "R8 start_pulse", start_pulse, m_start);
    chk(done_clr == m_done, "R8 done_clr", done_clr, m_done);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_we = 0; bus_addr = a;
    #1;
    chk(bus_rdata == exp, req, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic compare_all();
    rd(12'h000, m_ctrl, "R11 ctrl");
    rd(12'h004, m_ew, "R6 status");
    rd(12'h008, m_req[63:32], "R2 req hi");
    rd(12'h00C, m_req[31:0], "R2 req lo");
    rd(12'h010, m_eei[63:32], "R2 eei hi");
    rd(12'h014, m_eei[31:0], "R2 eei lo");
    rd(12'h020, m_int[63:32], "R4 int hi");
    rd(12'h024, m_int[31:0], "R4 int lo");
    rd(12'h028, m_err[63:32], "R5 err hi");
    rd(12'h02C, m_err[31:0], "R5 err lo");
    rd(12'h030, m_hw[63:32], "R12 hrs hi");
    rd(12'h034, m_hw[31:0], "R12 hrs lo");
    rd(12'h018, 32'h0, "R12 unmapped");
    for (int w = 0; w < N / 4; w++)
      rd(12'h100 + 12'(4 * w), {m_prio[4*w+3], m_prio[4*w+2], m_prio[4*w+1], m_prio[4*w]},
         "R12 prio");
    chk({ctrl_clk_gate, ctrl_rr_grp, ctrl_rr_chan} == {m_ctrl[31], m_ctrl[3], m_ctrl[2]},
        "R11 ctrl outs", 64'({ctrl_clk_gate, ctrl_rr_grp, ctrl_rr_chan}),
        64'({m_ctrl[31], m_ctrl[3], m_ctrl[2]}));
  endtask

  function automatic logic [63:0] sparse();
    return {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
           & {$urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'h5EED);
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    compare_all();
    chk(req_en == 0 && irq_out == 0, "R1 outputs", {req_en[62:0], irq_out}, 64'd0);
    rd(12'h104, 32'h0706_0504, "R1 prio reset");

    // R3 set request enable on channel 40, then R10 out-of-range clear (40+64)
    cyc(1, 12'h018, 4'b0001, 32'd40, 0, 0, 0);
    chk(req_en[40] == 1'b1, "R3 set ch40", 64'(req_en[40]), 64'd1);
    cyc(1, 12'h018, 4'b0010, 32'h0000_6800, 0, 0, 0);
    chk(req_en[40] == 1'b1, "R10 byte 104 ignored", 64'(req_en[40]), 64'd1);
    cyc(1, 12'h018, 4'b0001, 32'h0000_00C5, 0, 0, 0);
    chk(req_en == 64'h0000_0100_0000_0000, "R10 byte C5 ignored", req_en,
        64'h0000_0100_0000_0000);

    // R6 simultaneous errors: lowest channel captured
    cyc(1, 12'h018, 4'b0100, 32'h0003_0000, 0, 0, 0);
    cyc(0, 12'h000, 4'b0000, 0, 0, (64'd1 << 9) | (64'd1 << 3), 10'h3FF);
    rd(12'h004, 32'h8000_C3FF, "R6 capture lowest");
    chk(irq_out == 1'b1, "R9 err and enable", 64'(irq_out), 64'd1);
    cyc(0, 12'h000, 4'b0000, 0, 0, 64'd1 << 20, 10'h001);
    rd(12'h004, 32'h8000_C3FF, "R6 held while valid");

    // R7 clear-error on channel 9 clears valid; new error then captured
    cyc(1, 12'h01C, 4'b0010, 32'h0000_0900, 0, 0, 0);
    rd(12'h004, 32'h0, "R7 cleared");
    cyc(0, 12'h000, 4'b0000, 0, 0, 64'd1 << 20, 10'h001);
    rd(12'h004, 32'h8000_1401, "R7 recapture");
    // R7 clear and new error in the same cycle
    cyc(1, 12'h01C, 4'b0010, 32'h0000_1400, 0, 64'd1 << 33, 10'h200);
    rd(12'h004, 32'h8000_A100, "R7 same-cycle capture");

    // R4 event wins over write-one-to-clear, then clear alone
    cyc(1, 12'h024, 4'b1111, 32'h20, 64'h20, 0, 0);
    rd(12'h024, 32'h20, "R4 event beats clear");
    cyc(1, 12'h024, 4'b1111, 32'h20, 0, 0, 0);
    rd(12'h024, 32'h0, "R4 w1c");

    // R8 start and done strobes
    cyc(1, 12'h01C, 4'b1100, 32'h0B07_0000, 0, 0, 0);
    chk(start_pulse == 64'h80, "R8 start ch7", start_pulse, 64'h80);
    chk(done_clr == 64'h800, "R8 done ch11", done_clr, 64'h800);
    cyc(0, 12'h000, 4'b0000, 0, 0, 0, 0);
    chk(start_pulse == 0, "R8 single cycle", start_pulse, 0);

    // R11 control mask
    cyc(1, 12'h000, 4'b1111, 32'hFFFF_FFFF, 0, 0, 0);
    rd(12'h000, 32'h8000_000C, "R11 mask");
    compare_all();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      logic [3:0]  be;
      int          op;
      op = int'($urandom % 6);
      be = 4'($urandom);
      d  = {8'($urandom % 80), 8'($urandom % 80), 8'($urandom % 80), 8'($urandom % 80)};
      case (op)
        0: a = 12'h018;
        1: a = 12'h01C;
        2: begin a = 12'(4 * ($urandom % 14)); d = $urandom; end
        3: begin a = 12'h100 + 12'(4 * ($urandom % 16)); d = $urandom; end
        default: a = 12'h000;
      endcase
      hw_req = {$urandom, $urandom};
      m_hw = hw_req;
      cyc(op < 4, a, be, d, sparse(), sparse() & sparse(), 10'($urandom));
      if (n % 64 == 63) compare_all();
    end
    compare_all();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule